// File: doc/BRIEF.md
# Float Instruction Pipeline with Latency-Derived Taps

This block is the execution back end of a small register-file processor. Its arithmetic is done by an external pipelined floating-point unit. On every clock one instruction word enters a delay line of decoded slots. When a slot reaches the issue tap, its operation starts in the float unit: add, subtract or multiply, with the two source registers as operands. The result is written into the destination register when the same slot reaches a later tap. That tap sits further along the line by the latency of the unit that did the work. The add latency is the sum of the denormalize, add and normalize stage counts. The multiply latency is the sum of the multiply and normalize stage counts. Both come from the same parameters that size the float unit, so the capture taps follow any change in that configuration.

The block has no interlock and no bypass. A program must place enough no-op words after an operation before anything reads its result: at least as many as that operation's latency. A first-order low-pass step shows the pattern: temp = u − y, m = temp × g, y = y + m, with the padding between each step. A host port loads and reads registers. A run counter, loaded at start, drives a completion flag.

Top module: `fpipe_core`

## Requirements
- R1: The instruction word is 19 bits: opcode in [18:15], destination register in [14:10], first source in [9:5], second source in [4:0]. The opcodes are 0 = no-op, 1 = add, 2 = subtract, 3 = multiply. Any other opcode behaves exactly as a no-op: nothing is issued and no register changes.
- R2: The word on `instr_in` at a rising edge enters tap 0. It moves one tap per clock and is issued while it sits at tap ISSUE_TAP. Each operation is issued exactly once, and at most one operation is issued in any cycle.
- R3: While an add is at the issue tap, `add_go` is 1, `add_lhs` is register[src1] and `add_rhs` is register[src2].
- R4: While a subtract is at the issue tap, `add_go` is 1, `add_lhs` is register[src1] and `add_rhs` is register[src2] with bit DATA_W-1 inverted.
- R5: While a multiply is at the issue tap, `mpy_go` is 1, `mpy_lhs` is register[src1] and `mpy_rhs` is register[src2].
- R6: An add or subtract issued in cycle c writes `add_sum` into its destination register at the edge that ends cycle c + ADD_LAT, where ADD_LAT = DENORM_STAGES + ADD_STAGES + NORM_STAGES.
- R7: A multiply issued in cycle c writes `mpy_prod` into its destination register at the edge that ends cycle c + MPY_LAT, where MPY_LAT = MPY_STAGES + NORM_STAGES.
- R8: If an add/subtract writeback and a multiply writeback target the same register at the same edge, the multiply value is kept.
- R9: Operands are read from the register file as it stands in the issue cycle. A writeback at the edge that ends the issue cycle is not forwarded.
- R10: `ld_en` writes `ld_data` into register `ld_idx` at the edge. A pipeline writeback to the same register at the same edge takes priority. `rd_data` shows register `rd_idx` combinationally.
- R11: `start` loads a run counter with `run_len`. The counter then counts down by one per clock to zero. `program_done` is 1 exactly when the counter is zero and every tap holds a no-op.
- R12: A synchronous active-low reset clears every register and every tap to no-op. Directly after reset, `program_done` is 1 and no issue strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_in | input | 19 | Instruction word taken every clock |
| start | input | 1 | Loads the run counter |
| run_len | input | CNT_W | Run counter load value |
| ld_en | input | 1 | Host register write enable |
| ld_idx | input | 5 | Host write register index |
| ld_data | input | DATA_W | Host write data |
| rd_idx | input | 5 | Host read register index |
| rd_data | output | DATA_W | Host read data |
| add_go | output | 1 | Starts an add in the float unit |
| add_lhs | output | DATA_W | Adder first operand |
| add_rhs | output | DATA_W | Adder second operand (sign flipped for subtract) |
| add_sum | input | DATA_W | Adder result, ADD_LAT cycles after issue |
| mpy_go | output | 1 | Starts a multiply in the float unit |
| mpy_lhs | output | DATA_W | Multiplier first operand |
| mpy_rhs | output | DATA_W | Multiplier second operand |
| mpy_prod | input | DATA_W | Multiplier result, MPY_LAT cycles after issue |
| program_done | output | 1 | Counter expired and pipeline empty |

## Verification
The bench targets the timing of each capture tap. It runs the low-pass sequence with exactly the required padding, so a capture one tap early or late leaves stale or wrong values in temp, m and y. It lands an add and a multiply on the same register at the same edge: reversed priority keeps the sum. It issues an operation that reads a register in the very cycle that register is written: forwarding shows the new value where the old one is expected. It also streams unknown opcodes, which must not issue anything or write anything. And it makes the host load race a writeback, where wrong priority leaves the host value in place.

// File: rtl/fpipe_pkg.sv
// Shared types for the float instruction pipeline.
// Assumes a fixed 19-bit word: 4-bit opcode and three 5-bit register indices.
package fpipe_pkg;
    localparam int OPC_W  = 4;
    localparam int IDX_W  = 5;
    localparam int WORD_W = OPC_W + 3 * IDX_W;
    localparam int NREG   = 1 << IDX_W;

    typedef enum logic [1:0] {OP_NOP, OP_ADD, OP_SUB, OP_MPY} op_e;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] a1;
        logic [IDX_W-1:0] a2;
    } slot_t;

    localparam slot_t NOP_SLOT = '{op: OP_NOP, dst: '0, a1: '0, a2: '0};

    // Turn a raw word into a slot; unknown opcodes become a clean no-op.
    function automatic slot_t decode_word(input logic [WORD_W-1:0] w);
        slot_t s;
        s.dst = w[3*IDX_W-1 -: IDX_W];
        s.a1  = w[2*IDX_W-1 -: IDX_W];
        s.a2  = w[IDX_W-1:0];
        case (w[WORD_W-1 -: OPC_W])
            OPC_W'(1): s.op = OP_ADD;
            OPC_W'(2): s.op = OP_SUB;
            OPC_W'(3): s.op = OP_MPY;
            default:   s = NOP_SLOT;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/fpipe_tapline.sv
// Delay line of decoded instruction slots, one tap per clock.
// Assumes DEPTH >= 1; tap 0 holds the most recently accepted word.
module fpipe_tapline
    import fpipe_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t slot_in,
    output slot_t taps [DEPTH]
);
    slot_t q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        if (k == 0) begin : g_head
            // Accept the newest slot.
            always_ff @(posedge clk) begin
                if (!rst_n) q[k] <= NOP_SLOT;
                else        q[k] <= slot_in;
            end
        end else begin : g_body
            // Advance the slot one position.
            always_ff @(posedge clk) begin
                if (!rst_n) q[k] <= NOP_SLOT;
                else        q[k] <= q[k-1];
            end

            // R2
            shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (taps[k] == $past(taps[k-1])));
        end
        assign taps[k] = q[k];
    end
endmodule

// File: rtl/fpipe_regfile.sv
// Register file: host write plus two pipeline writeback ports, combinational reads.
// Priority at one edge and one index: multiply port over add port over host.
module fpipe_regfile
    import fpipe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [IDX_W-1:0]  rsel [NRD],
    output logic [DATA_W-1:0] rval [NRD]
);
    logic [DATA_W-1:0] mem [NREG];

    // Apply writes; later statements win on the same index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            if (ld_en) mem[ld_idx] <= ld_data;
            if (wa_en) mem[wa_idx] <= wa_data;
            if (wb_en) mem[wb_idx] <= wb_data;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rval[r] = mem[rsel[r]];
    end

    // R8
    mpy_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (mem[$past(wb_idx)] == $past(wb_data)));

    // R6
    add_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wa_en && !(wb_en && wb_idx == wa_idx) |=> (mem[$past(wa_idx)] == $past(wa_data)));

    // R10
    host_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && !(wa_en && wa_idx == ld_idx) && !(wb_en && wb_idx == ld_idx)
        |=> (mem[$past(ld_idx)] == $past(ld_data)));
endmodule

// File: rtl/fpipe_done.sv
// Run counter and completion flag.
// Assumes the caller supplies a flag telling whether every tap holds a no-op.
module fpipe_done #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             pipe_empty,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0) && pipe_empty;

    // R11
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && (len != '0) |=> !done);
endmodule

// File: rtl/fpipe_core.sv
// In-order float instruction pipeline. Issue and capture taps come from the
// float unit's stage counts. There is no interlock and no forwarding:
// software pads dependent operations with no-op words.
module fpipe_core
    import fpipe_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int CNT_W         = 8,
    parameter int DENORM_STAGES = 1,
    parameter int ADD_STAGES    = 1,
    parameter int NORM_STAGES   = 1,
    parameter int MPY_STAGES    = 1,
    parameter int ISSUE_TAP     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr_in,
    input  logic              start,
    input  logic [CNT_W-1:0]  run_len,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              add_go,
    output logic [DATA_W-1:0] add_lhs,
    output logic [DATA_W-1:0] add_rhs,
    input  logic [DATA_W-1:0] add_sum,
    output logic              mpy_go,
    output logic [DATA_W-1:0] mpy_lhs,
    output logic [DATA_W-1:0] mpy_rhs,
    input  logic [DATA_W-1:0] mpy_prod,
    output logic              program_done
);
    localparam int ADD_LAT = DENORM_STAGES + ADD_STAGES + NORM_STAGES;
    localparam int MPY_LAT = MPY_STAGES + NORM_STAGES;
    localparam int MAX_LAT = (ADD_LAT > MPY_LAT) ? ADD_LAT : MPY_LAT;
    localparam int DEPTH   = ISSUE_TAP + MAX_LAT + 1;
    localparam int ADD_CAP = ISSUE_TAP + ADD_LAT;
    localparam int MPY_CAP = ISSUE_TAP + MPY_LAT;
    localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};

    slot_t             taps [DEPTH];
    slot_t             iss, add_cap, mpy_cap;
    logic [IDX_W-1:0]  rsel [3];
    logic [DATA_W-1:0] rval [3];
    logic              wa_en, wb_en;
    logic [DEPTH-1:0]  busy;

    fpipe_tapline #(.DEPTH(DEPTH)) u_taps (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_in (decode_word(instr_in)),
        .taps    (taps)
    );

    assign iss     = taps[ISSUE_TAP];
    assign add_cap = taps[ADD_CAP];
    assign mpy_cap = taps[MPY_CAP];

    // Operand and host read selects.
    assign rsel[0] = iss.a1;
    assign rsel[1] = iss.a2;
    assign rsel[2] = rd_idx;

    // Drive the float unit from the slot at the issue tap.
    always_comb begin
        add_go  = (iss.op == OP_ADD) || (iss.op == OP_SUB);
        mpy_go  = (iss.op == OP_MPY);
        add_lhs = rval[0];
        add_rhs = (iss.op == OP_SUB) ? (rval[1] ^ SIGN_BIT) : rval[1];
        mpy_lhs = rval[0];
        mpy_rhs = rval[1];
    end

    // Capture results at the latency-offset taps.
    always_comb begin
        wa_en = (add_cap.op == OP_ADD) || (add_cap.op == OP_SUB);
        wb_en = (mpy_cap.op == OP_MPY);
    end

    fpipe_regfile #(.DATA_W(DATA_W), .NRD(3)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .wa_en   (wa_en),
        .wa_idx  (add_cap.dst),
        .wa_data (add_sum),
        .wb_en   (wb_en),
        .wb_idx  (mpy_cap.dst),
        .wb_data (mpy_prod),
        .rsel    (rsel),
        .rval    (rval)
    );

    assign rd_data = rval[2];

    for (genvar k = 0; k < DEPTH; k++) begin : g_busy
        assign busy[k] = (taps[k].op != OP_NOP);
    end

    fpipe_done #(.CNT_W(CNT_W)) u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .len        (run_len),
        .pipe_empty (busy == '0),
        .done       (program_done)
    );

    // R11
    issue_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_go || mpy_go) |-> !program_done);

    // R4
    sub_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_go && (iss.op == OP_SUB) |-> (add_rhs == (mpy_rhs ^ SIGN_BIT)));

    // R2
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_go && mpy_go));
endmodule

// File: tb/fpipe_core_test.sv
// Bench: behavioural model of program order, issue and writeback timing,
// compared with the design in every cycle.
module fpipe_core_test;
    localparam int ISS  = 1;
    localparam int ALAT = 3;   // 1 denorm + 1 add + 1 norm
    localparam int MLAT = 2;   // 1 mpy + 1 norm
    localparam int DEP  = ISS + 3 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] instr_in = '0;
    logic        start = 1'b0;
    logic [7:0]  run_len = '0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        add_go, mpy_go, program_done;
    logic [31:0] add_lhs, add_rhs, mpy_lhs, mpy_rhs, add_sum, mpy_prod;

    always #10 clk = ~clk;

    fpipe_core #(.ISSUE_TAP(ISS)) uut (
        .clk(clk), .rst_n(rst_n), .instr_in(instr_in), .start(start),
        .run_len(run_len), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .add_go(add_go), .add_lhs(add_lhs),
        .add_rhs(add_rhs), .add_sum(add_sum), .mpy_go(mpy_go), .mpy_lhs(mpy_lhs),
        .mpy_rhs(mpy_rhs), .mpy_prod(mpy_prod), .program_done(program_done)
    );

    // Stand-in float unit: integer add and multiply, fixed latency.
    logic [31:0] apipe [ALAT];
    logic [31:0] mpipe [MLAT];
    always @(posedge clk) begin
        apipe[0] <= add_lhs + add_rhs;
        for (int i = 1; i < ALAT; i++) apipe[i] <= apipe[i-1];
        mpipe[0] <= mpy_lhs * mpy_rhs;
        for (int i = 1; i < MLAT; i++) mpipe[i] <= mpipe[i-1];
    end
    assign add_sum  = apipe[ALAT-1];
    assign mpy_prod = mpipe[MLAT-1];

    int checks = 0, failures = 0, n = 0, mcnt = 0, watch = -1;
    bit finished = 1'b0;
    logic [18:0] hist [0:2047];
    logic [31:0] res  [0:2047];
    logic [31:0] mregs [32];

    function automatic logic [18:0] enc(int op, int d, int a, int b);
        return {op[3:0], d[4:0], a[4:0], b[4:0]};
    endfunction
    function automatic logic [18:0] hget(int i);
        return (i < 1) ? 19'd0 : hist[i];
    endfunction
    function automatic int opof(logic [18:0] w);
        return (w[18:15] >= 4'd1 && w[18:15] <= 4'd3) ? int'(w[18:15]) : 0;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", req, n, act, exp);
        end
    endtask

    // Compare the current cycle against the model.
    task automatic compare();
        logic [18:0] w;
        int op;
        logic [31:0] a, b, r;
        bit empty;
        w  = hget(n - ISS);
        op = opof(w);
        a  = mregs[w[9:5]];
        b  = mregs[w[4:0]];
        r  = 32'd0;
        // R1 R2 R3 R4: adder issue strobe and operands
        chk(add_go == (op == 1 || op == 2), "R1/R2 add_go", {31'd0, add_go}, {31'd0, (op == 1 || op == 2)});
        if (op == 1) begin
            r = a + b;
            chk(add_lhs == a && add_rhs == b, "R3 add operands", add_rhs, b);
        end else if (op == 2) begin
            r = a + (b ^ 32'h8000_0000);
            chk(add_lhs == a && add_rhs == (b ^ 32'h8000_0000), "R4 sub operands", add_rhs, b ^ 32'h8000_0000);
        end
        // R5: multiplier issue
        chk(mpy_go == (op == 3), "R5 mpy_go", {31'd0, mpy_go}, {31'd0, (op == 3)});
        if (op == 3) begin
            r = a * b;
            chk(mpy_lhs == a && mpy_rhs == b, "R5 mpy operands", mpy_rhs, b);
        end
        if (n - ISS >= 1) res[n - ISS] = r;
        // R11: completion flag
        empty = 1'b1;
        for (int k = 0; k < DEP; k++) if (opof(hget(n - k)) != 0) empty = 1'b0;
        chk(program_done == (mcnt == 0 && empty), "R11 program_done",
            {31'd0, program_done}, {31'd0, (mcnt == 0 && empty)});
        // R6 R7 R8 R9 R10 R12: register contents through the read port
        chk(rd_data == mregs[rd_idx], "R6/R7/R8/R9/R10/R12 register", rd_data, mregs[rd_idx]);
    endtask

    // One clock: check, drive, update the model, advance.
    task automatic step(logic [18:0] w, bit ld = 0, int li = 0, logic [31:0] ldv = 0,
                        bit st = 0, int len = 0);
        logic [18:0] x;
        compare();
        instr_in = w;
        ld_en = ld; ld_idx = li[4:0]; ld_data = ldv;
        start = st; run_len = len[7:0];
        if (ld) mregs[li] = ldv;
        x = hget(n - ISS - ALAT);
        if (opof(x) == 1 || opof(x) == 2) mregs[x[14:10]] = res[n - ISS - ALAT];
        x = hget(n - ISS - MLAT);
        if (opof(x) == 3) mregs[x[14:10]] = res[n - ISS - MLAT];
        if (st) mcnt = len; else if (mcnt > 0) mcnt--;
        hist[n + 1] = w;
        rd_idx = (watch >= 0) ? watch[4:0] : 5'((n + 1) % 32);
        @(posedge clk);
        n++;
        @(negedge clk);
    endtask

    task automatic nops(int k);
        for (int i = 0; i < k; i++) step(19'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mregs[i] = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: registers cleared, done high, no issue
        nops(33);
        // R10: host loads u, y, g
        step(19'd0, 1, 1, 32'd100);
        step(19'd0, 1, 2, 32'd30);
        step(19'd0, 1, 3, 32'd5);
        nops(2);
        // R6 R7 R4: low-pass step, padded with exactly the latency, run twice
        for (int it = 0; it < 2; it++) begin
            step(enc(2, 4, 1, 2), 0, 0, 0, 1, 11);
            nops(ALAT);
            step(enc(3, 5, 4, 3));
            nops(MLAT);
            step(enc(1, 2, 2, 5));
            nops(ALAT);
            nops(4);
        end
        // R8: add and multiply land on r6 at the same edge
        step(enc(1, 6, 1, 3));
        step(enc(3, 6, 1, 3));
        nops(8);
        watch = 6; nops(2); watch = -1;
        // R9: reader issues in the cycle its source is written
        step(enc(1, 7, 1, 1));
        nops(2);
        step(enc(1, 8, 7, 3));
        nops(6);
        watch = 8; nops(1); watch = 7; nops(1); watch = -1;
        // R1: unknown opcodes do nothing
        for (int i = 4; i < 16; i++) step(enc(i, 1, 2, 3));
        nops(6);
        watch = 1; nops(1); watch = -1;
        // R10: host write races a writeback to r9
        step(enc(1, 9, 1, 2));
        watch = 9;
        for (int i = 0; i < 6; i++) step(19'd0, 1, 9, 32'hDEAD_0000 + i);
        nops(2);
        watch = -1;
        // R2 R11: full-rate independent stream under a run counter
        step(enc(1, 10, 1, 2), 0, 0, 0, 1, 20);
        for (int i = 0; i < 10; i++) step(enc((i % 3) + 1, 11 + i, 1 + (i % 3), 2));
        nops(30);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule